// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous host and an external asynchronous static memory of 32K words by 16 bits. The host presents one request at a time through a request/ready handshake, with a 15-bit word address, 16-bit write data, a two-bit lane mask and a direction flag. The controller turns each request into a timed sequence on the memory's active-low strobes (chip select, output enable, write enable and one strobe per byte lane), holds the address and data steady around the write pulse, and returns read data with a one-cycle valid pulse.

The number of clock cycles spent in each phase comes from parameters. The nanosecond limits for the write pulse, the read access and the bus release are divided by the clock period and rounded up. Bus contention is avoided in two ways. An idle cycle run is placed wherever the data bus changes direction, and the controller never drives the data pins while the memory's outputs are enabled. The data bus is modelled as separate in and out vectors plus a drive enable, ready to feed a pad.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, chip select, output enable, write enable and both lane strobes are high, the data drive is off, ready is high and valid is low.
- R2: A request is taken in a cycle where both request and ready are high. Ready is low from the next cycle until the operation's last active cycle, and each accepted request produces exactly one memory operation.
- R3: A write runs as follows. A setup cycle has chip select low, write enable high, the lane strobes active, the address on the pins and the data driven. Write enable is then low for WE_CYC cycles. A hold cycle with write enable high and everything else unchanged follows. Address, lane strobes and write data do not change from the setup cycle to the hold cycle.
- R4: A read holds chip select, output enable and the active lane strobes low, with the data drive off, for RD_CYC cycles. The data pins are sampled at the end of the last of these cycles, and valid is high in the following cycle.
- R5: The lane mask selects the byte lanes. Mask bit 0 drives the low-lane strobe (data bits 7:0) and mask bit 1 drives the high-lane strobe (bits 15:8); a mask bit of 1 enables the lane. A lane with mask bit 0 keeps its strobe high. It is not written, and it reads back as zero.
- R6: An operation whose direction differs from the previous operation's begins with TURN_CYC cycles in which all strobes are high and the data drive is off. This holds however long the controller has been idle. The first operation after reset has no such cycles.
- R7: An operation with the same direction as the previous one starts in the cycle after acceptance, with no idle cycles added.
- R8: Output enable goes low only in a cycle that follows a cycle with the data drive off. The data drive is never on while output enable is low.
- R9: WE_CYC, RD_CYC and TURN_CYC are each the ceiling of the corresponding nanosecond limit divided by the clock period, with a minimum of one.
- R10: Valid is high for exactly one cycle per read. Ready is high in that same cycle, so a new request can be accepted alongside the returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostReq | input | 1 | Request strobe |
| hostReady | output | 1 | Controller can take a request |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 15 | Word address |
| hostWdata | input | 16 | Write data |
| hostMask | input | 2 | Lane enables, bit 0 low byte, bit 1 high byte |
| hostRdata | output | 16 | Read data, valid with hostValid |
| hostValid | output | 1 | One-cycle read completion pulse |
| memAddr | output | 15 | Memory address pins |
| memCeN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memLaneN | output | 2 | Byte lane strobes, active low, bit 0 low byte |
| memDataOut | output | 16 | Data toward the memory |
| memDataOe | output | 1 | Drive enable for memDataOut |
| memDataIn | input | 16 | Data from the memory |

## Verification
The completion of one read and the acceptance of the next request can fall in the same cycle. The valid pulse and ready share the first idle cycle, and a direction change decided in that cycle must still insert its idle run. The bench provokes this by issuing every back-to-back request in the first ready cycle it sees: read after read, write after read and read after write. Its behavioural model predicts every pin, ready and valid in every cycle and compares them. Read data is judged against a separate model of the memory contents that applies the lane masks.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC
  } ctrlState_t;

  typedef enum logic [1:0] {
    DIR_NONE,
    DIR_RD,
    DIR_WR
  } busDir_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // latch host request fields
    logic selChip;     // chip select active
    logic readEn;      // output enable active
    logic writePulse;  // write enable active
    logic laneEn;      // lane strobes follow the latched mask
    logic driveBus;    // drive the data pins
    logic capture;     // sample the data pins
  } ctrlStrobe_t;

  // ceiling of ns / clkNs, never below one cycle
  function automatic int cyclesFor(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int WE_CYC   = 1,
  parameter int RD_CYC   = 1,
  parameter int TURN_CYC = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hostReq,
  input  logic        hostWrite,
  output logic        hostReady,
  output ctrlStrobe_t strobe
);

  localparam int MAX_A   = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
  localparam int MAX_CYC = (MAX_A > TURN_CYC) ? MAX_A : TURN_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] WE_LD   = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  ctrlState_t       state, nextState;
  busDir_t          lastDir;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             accept;
  logic             needTurn;
  logic             cntDone;

  assign accept   = hostReq && (state == ST_IDLE);
  assign cntDone  = (cnt == '0);
  assign needTurn = (lastDir == DIR_RD && hostWrite) ||
                    (lastDir == DIR_WR && !hostWrite);

  always_comb begin
    nextState = state;
    cntNext   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (needTurn) begin
            nextState = ST_TURN;
            cntNext   = TURN_LD;
          end else if (hostWrite) begin
            nextState = ST_WSETUP;
          end else begin
            nextState = ST_RACC;
            cntNext   = RD_LD;
          end
        end
      end
      ST_TURN: begin
        if (cntDone) begin
          if (lastDir == DIR_WR) begin
            nextState = ST_WSETUP;
          end else begin
            nextState = ST_RACC;
            cntNext   = RD_LD;
          end
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_WSETUP: begin
        nextState = ST_WPULSE;
        cntNext   = WE_LD;
      end
      ST_WPULSE: begin
        if (cntDone) nextState = ST_WHOLD;
        else         cntNext   = cnt - 1'b1;
      end
      ST_WHOLD: begin
        nextState = ST_IDLE;
      end
      ST_RACC: begin
        if (cntDone) nextState = ST_IDLE;
        else         cntNext   = cnt - 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      lastDir <= DIR_NONE;
    end else begin
      state <= nextState;
      cnt   <= cntNext;
      if (accept) lastDir <= hostWrite ? DIR_WR : DIR_RD;
    end
  end

  logic inWrite;
  assign inWrite = (state == ST_WSETUP) || (state == ST_WPULSE) ||
                   (state == ST_WHOLD);

  assign hostReady         = (state == ST_IDLE);
  assign strobe.load       = accept;
  assign strobe.selChip    = inWrite || (state == ST_RACC);
  assign strobe.laneEn     = inWrite || (state == ST_RACC);
  assign strobe.readEn     = (state == ST_RACC);
  assign strobe.writePulse = (state == ST_WPULSE);
  assign strobe.driveBus   = inWrite;
  assign strobe.capture    = (state == ST_RACC) && cntDone;

  // R2: an accepted request drops ready in the next cycle
  p_ready_drops_r2: assert property (@(posedge clk) disable iff (rst)
    (hostReq && hostReady) |=> !hostReady);

  // R6: the drive is never switched on right after output enable was active
  p_no_direct_flip_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe.driveBus) |-> !$past(strobe.readEn));

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrlStrobe_t              strobe,
  input  logic [ADDR_W-1:0]        hostAddr,
  input  logic [DATA_W-1:0]        hostWdata,
  input  logic [DATA_W/LANE_W-1:0] hostMask,
  output logic [DATA_W-1:0]        hostRdata,
  output logic                     hostValid,
  output logic [ADDR_W-1:0]        memAddr,
  output logic                     memCeN,
  output logic                     memOeN,
  output logic                     memWeN,
  output logic [DATA_W/LANE_W-1:0] memLaneN,
  output logic [DATA_W-1:0]        memDataOut,
  output logic                     memDataOe,
  input  logic [DATA_W-1:0]        memDataIn
);

  localparam int LANES = DATA_W / LANE_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  maskQ;
  logic              validQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
    end else if (strobe.load) begin
      addrQ  <= hostAddr;
      wdataQ <= hostWdata;
      maskQ  <= hostMask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= strobe.capture;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] rdLane;
    always_ff @(posedge clk) begin
      if (rst) begin
        rdLane <= '0;
      end else if (strobe.capture) begin
        rdLane <= maskQ[g] ? memDataIn[g*LANE_W +: LANE_W] : '0;
      end
    end
    assign hostRdata[g*LANE_W +: LANE_W] = rdLane;
    assign memLaneN[g] = !(strobe.laneEn && maskQ[g]);
  end

  assign hostValid  = validQ;
  assign memAddr    = addrQ;
  assign memDataOut = wdataQ;
  assign memDataOe  = strobe.driveBus;
  assign memCeN     = !strobe.selChip;
  assign memOeN     = !strobe.readEn;
  assign memWeN     = !strobe.writePulse;

  // R3: address, data and lanes are steady while write enable is low
  p_we_stable_r3: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> ($stable(memAddr) && $stable(memDataOut) && $stable(memLaneN)));

  // R3: one hold cycle after the write pulse, still selected and driving
  p_we_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |-> ($stable(memAddr) && memDataOe && !memCeN));

  // R8: output enable falls only after a cycle without drive
  p_oe_after_release_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(memOeN) |-> !$past(memDataOe));

  // R10: valid is a single-cycle pulse
  p_valid_single_r10: assert property (@(posedge clk) disable iff (rst)
    hostValid |=> !hostValid);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 16,
  parameter int LANE_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_WE_NS   = 7,
  parameter int T_ACC_NS  = 10,
  parameter int T_HIZ_NS  = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     hostReq,
  output logic                     hostReady,
  input  logic                     hostWrite,
  input  logic [ADDR_W-1:0]        hostAddr,
  input  logic [DATA_W-1:0]        hostWdata,
  input  logic [DATA_W/LANE_W-1:0] hostMask,
  output logic [DATA_W-1:0]        hostRdata,
  output logic                     hostValid,
  output logic [ADDR_W-1:0]        memAddr,
  output logic                     memCeN,
  output logic                     memOeN,
  output logic                     memWeN,
  output logic [DATA_W/LANE_W-1:0] memLaneN,
  output logic [DATA_W-1:0]        memDataOut,
  output logic                     memDataOe,
  input  logic [DATA_W-1:0]        memDataIn
);

  // R9: phase lengths from the nanosecond limits
  localparam int WE_CYC   = cyclesFor(T_WE_NS, CLK_NS);
  localparam int RD_CYC   = cyclesFor(T_ACC_NS, CLK_NS);
  localparam int TURN_CYC = cyclesFor(T_HIZ_NS, CLK_NS);

  ctrlStrobe_t strobe;

  sram_ctrl_fsm #(
    .WE_CYC  (WE_CYC),
    .RD_CYC  (RD_CYC),
    .TURN_CYC(TURN_CYC)
  ) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .hostReq  (hostReq),
    .hostWrite(hostWrite),
    .hostReady(hostReady),
    .strobe   (strobe)
  );

  sram_ctrl_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANE_W(LANE_W)
  ) uPath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostMask  (hostMask),
    .hostRdata (hostRdata),
    .hostValid (hostValid),
    .memAddr   (memAddr),
    .memCeN    (memCeN),
    .memOeN    (memOeN),
    .memWeN    (memWeN),
    .memLaneN  (memLaneN),
    .memDataOut(memDataOut),
    .memDataOe (memDataOe),
    .memDataIn (memDataIn)
  );

endmodule

// File: tb/tb_sram_lane_ctrl.sv
`timescale 1ns/1ps
module tb_sram_lane_ctrl;

  localparam int CLK_PERIOD = 4;
  localparam int T_WE = 7, T_ACC = 10, T_HIZ = 5;
  // R9: expected phase lengths, ceiling with a floor of one
  localparam int WE_EXP   = ((T_WE  + CLK_PERIOD - 1) / CLK_PERIOD) < 1 ? 1 : (T_WE  + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RD_EXP   = ((T_ACC + CLK_PERIOD - 1) / CLK_PERIOD) < 1 ? 1 : (T_ACC + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int TURN_EXP = ((T_HIZ + CLK_PERIOD - 1) / CLK_PERIOD) < 1 ? 1 : (T_HIZ + CLK_PERIOD - 1) / CLK_PERIOD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hostReq = 1'b0, hostWrite = 1'b0;
  logic [14:0] hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [1:0]  hostMask = '0;
  logic hostReady, hostValid;
  logic [15:0] hostRdata;
  logic [14:0] memAddr;
  logic memCeN, memOeN, memWeN, memDataOe;
  logic [1:0]  memLaneN;
  logic [15:0] memDataOut, memDataIn;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_ctrl #(
    .CLK_NS(CLK_PERIOD), .T_WE_NS(T_WE), .T_ACC_NS(T_ACC), .T_HIZ_NS(T_HIZ)
  ) dut (
    .clk(clk), .rst(rst), .hostReq(hostReq), .hostReady(hostReady),
    .hostWrite(hostWrite), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostMask(hostMask), .hostRdata(hostRdata), .hostValid(hostValid),
    .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memLaneN(memLaneN), .memDataOut(memDataOut), .memDataOe(memDataOe),
    .memDataIn(memDataIn)
  );

  // behavioural memory on the pins
  logic [15:0] sram [32768];
  always @(*) begin
    memDataIn = 16'hDEAD;
    if (!memCeN && !memOeN && memWeN) begin
      if (!memLaneN[0]) memDataIn[7:0]  = sram[memAddr][7:0];
      if (!memLaneN[1]) memDataIn[15:8] = sram[memAddr][15:8];
    end
  end
  always @(posedge clk) begin
    if (!memCeN && !memWeN) begin
      if (!memLaneN[0]) sram[memAddr][7:0]  <= memDataOut[7:0];
      if (!memLaneN[1]) sram[memAddr][15:8] <= memDataOut[15:8];
    end
  end

  // reference model
  typedef struct {
    bit ceN, oeN, weN, doe, rdy, lastRead;
    bit [1:0] laneN;
    bit [14:0] addr;
    bit [15:0] wd, rdExp;
    string tag;
  } rec_t;

  typedef struct {
    bit wr;
    bit [14:0] addr;
    bit [15:0] data;
    bit [1:0] mask;
    int gap;
    string tag;
  } op_t;

  rec_t q[$];
  op_t  ops[$];
  bit [15:0] refMem [32768];
  int checks = 0, failures = 0;
  int gapCnt = 0, opIdx = 0, lastDir = 0;
  bit pendValid = 0;
  bit [15:0] pendData = '0;
  bit done = 0;
  int wdog = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic rec_t idleRec(input string tag, input bit rdy);
    rec_t r;
    r.ceN = 1; r.oeN = 1; r.weN = 1; r.doe = 0; r.rdy = rdy; r.lastRead = 0;
    r.laneN = 2'b11; r.addr = '0; r.wd = '0; r.rdExp = '0; r.tag = tag;
    return r;
  endfunction

  task automatic schedule(input op_t o);
    rec_t r;
    int dir = o.wr ? 2 : 1;
    if (lastDir != 0 && lastDir != dir)
      for (int t = 0; t < TURN_EXP; t++) q.push_back(idleRec("R6", 0));
    r = idleRec(o.tag, 0);
    r.ceN = 0; r.laneN = ~o.mask; r.addr = o.addr;
    if (o.wr) begin
      r.doe = 1; r.wd = o.data;
      q.push_back(r);
      r.weN = 0;
      for (int t = 0; t < WE_EXP; t++) q.push_back(r);
      r.weN = 1;
      q.push_back(r);
      if (o.mask[0]) refMem[o.addr][7:0]  = o.data[7:0];
      if (o.mask[1]) refMem[o.addr][15:8] = o.data[15:8];
    end else begin
      r.oeN = 0;
      r.rdExp = refMem[o.addr] & {{8{o.mask[1]}}, {8{o.mask[0]}}};
      for (int t = 0; t < RD_EXP; t++) begin
        r.lastRead = (t == RD_EXP - 1);
        q.push_back(r);
      end
    end
    lastDir = dir;
  endtask

  task automatic compareCycle(input rec_t r, input bit expValid, input bit [15:0] expData);
    logic [7:0] act, exp;
    act = {memCeN, memOeN, memWeN, memLaneN, memDataOe, hostReady, hostValid};
    exp = {r.ceN, r.oeN, r.weN, r.laneN, r.doe, r.rdy, expValid};
    check(act == exp, r.tag, "pins{ce,oe,we,lane,oe_drv,ready,valid}", 32'(act), 32'(exp));
    if (!r.ceN) check(memAddr == r.addr, r.tag, "address", 32'(memAddr), 32'(r.addr));
    if (r.doe)  check(memDataOut == r.wd, r.tag, "write data", 32'(memDataOut), 32'(r.wd));
    if (expValid) check(hostRdata == expData, "R4", "read data", 32'(hostRdata), 32'(expData));
  endtask

  task automatic step();
    rec_t r;
    @(negedge clk);
    if (q.size() > 0) r = q.pop_front();
    else              r = idleRec("R2", 1);
    compareCycle(r, pendValid, pendData);
    pendValid = r.lastRead;
    pendData  = r.rdExp;
    hostReq = 0;
    if (r.rdy) begin
      if (opIdx < ops.size() && gapCnt >= ops[opIdx].gap) begin
        hostReq = 1;
        hostWrite = ops[opIdx].wr;
        hostAddr  = ops[opIdx].addr;
        hostWdata = ops[opIdx].data;
        hostMask  = ops[opIdx].mask;
        schedule(ops[opIdx]);
        opIdx++;
        gapCnt = 0;
      end else begin
        gapCnt++;
      end
    end
  endtask

  function automatic op_t mk(input bit wr, input bit [14:0] a, input bit [15:0] d,
                             input bit [1:0] m, input int gap, input string tag);
    op_t o;
    o.wr = wr; o.addr = a; o.data = d; o.mask = m; o.gap = gap; o.tag = tag;
    return o;
  endfunction

  initial begin
    for (int i = 0; i < 32768; i++) begin
      sram[i] = '0;
      refMem[i] = '0;
    end
    // R3 writes, R7 back-to-back, R6 direction changes, R5 lane masks, R10 same-cycle accept
    ops.push_back(mk(1, 15'h0010, 16'h1234, 2'b11, 2, "R3"));
    ops.push_back(mk(1, 15'h7FFF, 16'hBEEF, 2'b11, 0, "R7"));
    ops.push_back(mk(0, 15'h0010, 16'h0000, 2'b11, 0, "R4"));
    ops.push_back(mk(0, 15'h7FFF, 16'h0000, 2'b11, 0, "R10"));
    ops.push_back(mk(1, 15'h0010, 16'h5566, 2'b10, 0, "R5"));
    ops.push_back(mk(1, 15'h0020, 16'hFFFF, 2'b00, 0, "R5"));
    ops.push_back(mk(0, 15'h0010, 16'h0000, 2'b11, 0, "R5"));
    ops.push_back(mk(0, 15'h0020, 16'h0000, 2'b11, 0, "R5"));
    ops.push_back(mk(0, 15'h7FFF, 16'h0000, 2'b01, 0, "R5"));
    ops.push_back(mk(0, 15'h0010, 16'h0000, 2'b10, 1, "R7"));
    ops.push_back(mk(1, 15'h0010, 16'h0077, 2'b01, 3, "R6"));
    ops.push_back(mk(0, 15'h0010, 16'h0000, 2'b11, 5, "R6"));
    ops.push_back(mk(0, 15'h7FFF, 16'h0000, 2'b00, 0, "R5"));
    ops.push_back(mk(1, 15'h0001, 16'hA55A, 2'b11, 0, "R8"));
    ops.push_back(mk(0, 15'h0001, 16'h0000, 2'b11, 0, "R8"));

    // R1: reset state
    rst = 1;
    repeat (3) begin
      @(negedge clk);
      compareCycle(idleRec("R1", 1), 0, '0);
    end
    rst = 0;
    q.push_back(idleRec("R1", 1));
    while (opIdx < ops.size() || q.size() > 0 || pendValid) step();
    repeat (4) step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    wdog++;
    if (wdog > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", wdog, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule